// File: doc/BRIEF.md
# Automatic Xon/Xoff Flow Controller

This block sits between a UART receiver, its receive FIFO, its transmit FIFO and its transmit serializer, and runs software flow control for one channel without processor help. Each received character is compared against four programmable flow characters, two "resume" and two "stop". The comparison uses only the bits of the configured word length. Recognized flow characters are consumed and never reach the receive FIFO. A stop character holds back transmit FIFO data and a resume character releases it. Holding back acts only at character boundaries, that is, at serializer handshakes.

The block also watches the receive FIFO fill level against a trigger level. When the level rises above the trigger, it inserts the stop character(s) into the transmit stream, once per crossing. When the level later falls below the trigger, it inserts the resume character(s). Inserted characters take precedence over transmit FIFO data and are sent even while transmission is held.

With all flow-mode bits at zero, a special-character mode can be enabled. In that mode every received character is compared with the second stop character. A match is still stored in the FIFO and produces a one-cycle hit pulse.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `tx_paused`, `spec_hit`, `fifo_wr_valid` and `ser_valid` are 0 while `rx_valid` and `txq_valid` are 0, and no flow character is pending.
- R2: All comparisons use only the low 5, 6, 7 or 8 bits, selected by `cfg_wlen` = 0, 1, 2 or 3. Bit 0 is the first received data bit. Inserted characters are masked the same way.
- R3: A received character recognized as a flow character is accepted (`rx_ready`=1) even when `fifo_wr_ready` is 0, and `fifo_wr_valid` stays 0 for it.
- R4: An accepted recognized stop character sets `tx_paused` from the next cycle, and a resume character clears it. If a character matches both, stop wins. While paused, `txq_ready` is 0 and queue data is not offered to the serializer.
- R5: A character that is not recognized is passed unchanged: `fifo_wr_valid`=`rx_valid`, `fifo_wr_data`=`rx_data`, `rx_ready`=`fifo_wr_ready`.
- R6: With a nonzero transmit select, `fifo_level` > `cfg_trig` while no stop was sent starts one stop sequence on the next cycle. No further stop sequence follows while the level stays above the trigger.
- R7: After a stop was sent, `fifo_level` < `cfg_trig` starts one resume sequence. A level equal to the trigger does nothing, and no resume is sent without a prior stop.
- R8: `cfg_flow_mode[3:2]` selects the transmit characters: 0 = none, 1 = first set, 2 = second set, 3 = first-set character followed by second-set character.
- R9: A pending inserted character is offered on `ser_*` ahead of queue data (`txq_ready`=0 while it is pending) and is sent even when paused.
- R10: With `cfg_spec_en`=1 and `cfg_flow_mode`=0, a received character that matches the masked second stop character is written to the FIFO and `spec_hit` pulses in its write cycle. With any mode bit set, `spec_hit` stays 0.
- R11: `cfg_flow_mode[1:0]` selects which received characters are recognized: 0 = none, 1 = first set, 2 = second set, 3 = either set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_xon1 | input | 8 | Resume character, first set |
| cfg_xon2 | input | 8 | Resume character, second set |
| cfg_xoff1 | input | 8 | Stop character, first set |
| cfg_xoff2 | input | 8 | Stop character, second set; also the special character |
| cfg_wlen | input | 2 | Word length code: 5 + value bits |
| cfg_flow_mode | input | 4 | [1:0] receive select, [3:2] transmit select |
| cfg_spec_en | input | 1 | Special-character mode enable |
| cfg_trig | input | LVL_W | Receive FIFO trigger level |
| rx_valid | input | 1 | Received character valid |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Received character accepted |
| fifo_wr_valid | output | 1 | Write to receive FIFO |
| fifo_wr_data | output | 8 | Character to receive FIFO |
| fifo_wr_ready | input | 1 | Receive FIFO can accept |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| txq_valid | input | 1 | Transmit FIFO has data |
| txq_data | input | 8 | Transmit FIFO head character |
| txq_ready | output | 1 | Transmit FIFO character taken |
| ser_valid | output | 1 | Character offered to serializer |
| ser_data | output | 8 | Character to serializer |
| ser_ready | input | 1 | Serializer takes character (character boundary) |
| tx_paused | output | 1 | Queue data held by received stop character |
| spec_hit | output | 1 | Special character stored this cycle |

## Verification
On every cycle the assertions check the following:
- Paused or insert-pending cycles never take queue data.
- Stop and resume sequences start only on the correct side of the trigger.
- A recognized stop always leads to the paused state.
- Dropped characters are always accepted.
- `spec_hit` only appears in plain mode with a write.

Only the bench's scenarios show other behaviour:
- The exact characters and their order for each transmit select.
- The word-length masking over every character value.
- The one-shot behaviour across repeated and equal levels.
- The interplay of pause and insertion.

// File: rtl/xonxoff_pkg.sv
package xonxoff_pkg;
    localparam int CHAR_W = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SET1 = 2'd1,
        SEL_SET2 = 2'd2,
        SEL_BOTH = 2'd3
    } set_sel_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FIRST,
        SQ_SECOND
    } seq_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] on1;
        logic [CHAR_W-1:0] off1;
        logic [CHAR_W-1:0] on2;
        logic [CHAR_W-1:0] off2;
    } flow_chars_t;

    function automatic logic [CHAR_W-1:0] word_mask(input logic [1:0] wlen);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) m[i] = (i < MIN_BITS + int'(wlen));
        return m;
    endfunction

    function automatic logic masked_eq(input logic [CHAR_W-1:0] a,
                                       input logic [CHAR_W-1:0] b,
                                       input logic [1:0] wlen);
        return ((a ^ b) & word_mask(wlen)) == '0;
    endfunction
endpackage

// File: rtl/flow_rx_match.sv
module flow_rx_match
    import xonxoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flow_chars_t       chars,
    input  logic [1:0]        wlen,
    input  set_sel_t          rx_sel,
    input  logic              spec_on,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              fifo_wr_valid,
    output logic [CHAR_W-1:0] fifo_wr_data,
    input  logic              fifo_wr_ready,
    output logic              tx_paused,
    output logic              spec_hit,
    output logic              is_stop
);
    logic m_on1, m_off1, m_on2, m_off2, is_go, drop;

    assign m_on1  = masked_eq(rx_data, chars.on1, wlen);
    assign m_off1 = masked_eq(rx_data, chars.off1, wlen);
    assign m_on2  = masked_eq(rx_data, chars.on2, wlen);
    assign m_off2 = masked_eq(rx_data, chars.off2, wlen);

    always_comb begin
        unique case (rx_sel)
            SEL_SET1: begin is_go = m_on1;          is_stop = m_off1;          end
            SEL_SET2: begin is_go = m_on2;          is_stop = m_off2;          end
            SEL_BOTH: begin is_go = m_on1 | m_on2;  is_stop = m_off1 | m_off2; end
            default:  begin is_go = 1'b0;           is_stop = 1'b0;            end
        endcase
    end

    assign drop          = is_go | is_stop;
    assign rx_ready      = drop | fifo_wr_ready;
    assign fifo_wr_valid = rx_valid & ~drop;
    assign fifo_wr_data  = rx_data;
    assign spec_hit      = spec_on & rx_valid & fifo_wr_ready & m_off2;

    always_ff @(posedge clk) begin
        if (rst)                        tx_paused <= 1'b0;
        else if (rx_valid && is_stop)   tx_paused <= 1'b1;
        else if (rx_valid && is_go)     tx_paused <= 1'b0;
    end
endmodule

// File: rtl/flow_tx_seq.sv
module flow_tx_seq
    import xonxoff_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  flow_chars_t       chars,
    input  logic [1:0]        wlen,
    input  set_sel_t          tx_sel,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  trig,
    output logic              ins_valid,
    output logic [CHAR_W-1:0] ins_data,
    input  logic              ins_ready,
    output logic              stop_sent
);
    seq_state_t        state;
    logic              send_go;
    logic [CHAR_W-1:0] first_c, second_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            stop_sent <= 1'b0;
            send_go   <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: if (tx_sel != SEL_NONE) begin
                    if (!stop_sent && level > trig) begin
                        state <= SQ_FIRST; send_go <= 1'b0; stop_sent <= 1'b1;
                    end else if (stop_sent && level < trig) begin
                        state <= SQ_FIRST; send_go <= 1'b1; stop_sent <= 1'b0;
                    end
                end
                SQ_FIRST:  if (ins_ready) state <= (tx_sel == SEL_BOTH) ? SQ_SECOND : SQ_IDLE;
                SQ_SECOND: if (ins_ready) state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        if (tx_sel == SEL_SET2) first_c = send_go ? chars.on2 : chars.off2;
        else                    first_c = send_go ? chars.on1 : chars.off1;
        second_c = send_go ? chars.on2 : chars.off2;
    end

    assign ins_valid = (state != SQ_IDLE);
    assign ins_data  = ((state == SQ_SECOND) ? second_c : first_c) & word_mask(wlen);
endmodule

// File: rtl/flow_tx_arb.sv
module flow_tx_arb
    import xonxoff_pkg::*;
(
    input  logic              ins_valid,
    input  logic [CHAR_W-1:0] ins_data,
    output logic              ins_ready,
    input  logic              txq_valid,
    input  logic [CHAR_W-1:0] txq_data,
    output logic              txq_ready,
    input  logic              paused,
    output logic              ser_valid,
    output logic [CHAR_W-1:0] ser_data,
    input  logic              ser_ready
);
    assign ser_valid = ins_valid | (txq_valid & ~paused);
    assign ser_data  = ins_valid ? ins_data : txq_data;
    assign ins_ready = ser_ready;
    assign txq_ready = ser_ready & ~ins_valid & ~paused;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
    import xonxoff_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_xon1,
    input  logic [7:0]        cfg_xon2,
    input  logic [7:0]        cfg_xoff1,
    input  logic [7:0]        cfg_xoff2,
    input  logic [1:0]        cfg_wlen,
    input  logic [3:0]        cfg_flow_mode,
    input  logic              cfg_spec_en,
    input  logic [LVL_W-1:0]  cfg_trig,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              fifo_wr_valid,
    output logic [7:0]        fifo_wr_data,
    input  logic              fifo_wr_ready,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              txq_valid,
    input  logic [7:0]        txq_data,
    output logic              txq_ready,
    output logic              ser_valid,
    output logic [7:0]        ser_data,
    input  logic              ser_ready,
    output logic              tx_paused,
    output logic              spec_hit
);
    flow_chars_t       chars;
    set_sel_t          rx_sel, tx_sel;
    logic              spec_on, rx_is_stop, stop_sent, ins_valid, ins_ready;
    logic [CHAR_W-1:0] ins_data;

    assign chars   = '{on1: cfg_xon1, off1: cfg_xoff1, on2: cfg_xon2, off2: cfg_xoff2};
    assign rx_sel  = set_sel_t'(cfg_flow_mode[1:0]);
    assign tx_sel  = set_sel_t'(cfg_flow_mode[3:2]);
    assign spec_on = cfg_spec_en & (cfg_flow_mode == 4'd0);

    flow_rx_match u_rx (
        .clk, .rst, .chars, .wlen(cfg_wlen), .rx_sel, .spec_on,
        .rx_valid, .rx_data, .rx_ready, .fifo_wr_valid, .fifo_wr_data,
        .fifo_wr_ready, .tx_paused, .spec_hit, .is_stop(rx_is_stop)
    );

    flow_tx_seq #(.LVL_W(LVL_W)) u_seq (
        .clk, .rst, .chars, .wlen(cfg_wlen), .tx_sel,
        .level(fifo_level), .trig(cfg_trig),
        .ins_valid, .ins_data, .ins_ready, .stop_sent
    );

    flow_tx_arb u_arb (
        .ins_valid, .ins_data, .ins_ready, .txq_valid, .txq_data, .txq_ready,
        .paused(tx_paused), .ser_valid, .ser_data, .ser_ready
    );
endmodule

// File: rtl/xonxoff_flow_chk.sv
module xonxoff_flow_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       cfg_flow_mode,
    input logic [LVL_W-1:0] cfg_trig,
    input logic [LVL_W-1:0] fifo_level,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             fifo_wr_valid,
    input logic             txq_ready,
    input logic             ser_valid,
    input logic             tx_paused,
    input logic             spec_hit,
    input logic             rx_is_stop,
    input logic             stop_sent,
    input logic             ins_valid
);
    // R4
    paused_holds_queue_chk: assert property (@(posedge clk) disable iff (rst)
        tx_paused |-> !txq_ready);
    // R9
    insert_ahead_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> (ser_valid && !txq_ready));
    // R6
    stop_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_sent) |-> $past(fifo_level > cfg_trig));
    // R7
    go_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_sent) |-> $past(fifo_level < cfg_trig));
    // R4
    stop_pauses_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_is_stop) |=> tx_paused);
    // R3
    dropped_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_is_stop) |-> (rx_ready && !fifo_wr_valid));
    // R10
    spec_plain_chk: assert property (@(posedge clk) disable iff (rst)
        spec_hit |-> (cfg_flow_mode == 4'd0 && fifo_wr_valid));
endmodule

bind xonxoff_flow_ctrl xonxoff_flow_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_flow_mode(cfg_flow_mode), .cfg_trig(cfg_trig),
    .fifo_level(fifo_level), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .fifo_wr_valid(fifo_wr_valid), .txq_ready(txq_ready), .ser_valid(ser_valid),
    .tx_paused(tx_paused), .spec_hit(spec_hit), .rx_is_stop(rx_is_stop),
    .stop_sent(stop_sent), .ins_valid(ins_valid)
);

// File: tb/test_xonxoff_flow_ctrl.sv
module test_xonxoff_flow_ctrl;
    localparam int LVL_W = 8;
    localparam logic [7:0] ON1 = 8'h11, OFF1 = 8'h13, ON2 = 8'h91, OFF2 = 8'h93;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic [3:0] cfg_flow_mode = 4'd0;
    logic cfg_spec_en = 1'b0;
    logic [LVL_W-1:0] cfg_trig = 8'd10, fifo_level = 8'd10;
    logic rx_valid = 1'b0, fifo_wr_ready = 1'b1, txq_valid = 1'b0, ser_ready = 1'b1;
    logic [7:0] rx_data = '0, txq_data = 8'h55;
    logic rx_ready, fifo_wr_valid, txq_ready, ser_valid, tx_paused, spec_hit;
    logic [7:0] fifo_wr_data, ser_data;

    int errors = 0, checks = 0, got_n = 0;
    logic [7:0] got [0:7];
    bit finished = 0;

    always #2 clk = ~clk;

    xonxoff_flow_ctrl #(.LVL_W(LVL_W)) i_xonxoff_flow_ctrl (
        .clk, .rst, .cfg_xon1(ON1), .cfg_xon2(ON2), .cfg_xoff1(OFF1), .cfg_xoff2(OFF2),
        .cfg_wlen, .cfg_flow_mode, .cfg_spec_en, .cfg_trig,
        .rx_valid, .rx_data, .rx_ready, .fifo_wr_valid, .fifo_wr_data, .fifo_wr_ready,
        .fifo_level, .txq_valid, .txq_data, .txq_ready, .ser_valid, .ser_data,
        .ser_ready, .tx_paused, .spec_hit
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic collect(input int ncyc);
        got_n = 0;
        repeat (ncyc) begin
            @(negedge clk); #1;
            if (ser_valid && ser_ready) begin
                if (got_n < 8) got[got_n] = ser_data;
                got_n++;
            end
        end
    endtask

    function automatic logic eqm(input logic [7:0] a, input logic [7:0] b, input int w);
        logic [7:0] m = 8'((1 << (5 + w)) - 1);
        return ((a & m) == (b & m));
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic exp_paused;
        do_reset();
        #1;
        // R1 reset state
        check("R1 paused", tx_paused, 0);
        check("R1 ser_valid", ser_valid, 0);
        check("R1 spec_hit", spec_hit, 0);
        check("R1 fifo_wr_valid", fifo_wr_valid, 0);

        // Sweep: R2 R3 R4 R5 R10 R11 over word length, receive select, every character
        cfg_spec_en = 1'b1;
        exp_paused = 1'b0;
        for (int w = 0; w < 4; w++) begin
            for (int rm = 0; rm < 4; rm++) begin
                for (int d = 0; d < 256; d++) begin
                    logic on, off, fwr, spx;
                    @(negedge clk);
                    cfg_wlen = 2'(w); cfg_flow_mode = {2'b00, 2'(rm)};
                    rx_valid = 1'b1; rx_data = 8'(d); fwr = d[1] ^ d[4];
                    fifo_wr_ready = fwr;
                    #1;
                    check("R4 paused", tx_paused, exp_paused);
                    on  = (rm == 1 || rm == 3) && eqm(8'(d), ON1, w) ||
                          (rm == 2 || rm == 3) && eqm(8'(d), ON2, w);
                    off = (rm == 1 || rm == 3) && eqm(8'(d), OFF1, w) ||
                          (rm == 2 || rm == 3) && eqm(8'(d), OFF2, w);
                    spx = (rm == 0) && fwr && eqm(8'(d), OFF2, w);
                    check("R3 R5 R11 R2 fifo_wr_valid", fifo_wr_valid, !(on || off));
                    check("R3 R5 rx_ready", rx_ready, (on || off) || fwr);
                    check("R5 fifo_wr_data", fifo_wr_data, d);
                    check("R10 spec_hit", spec_hit, spx);
                    if (off) exp_paused = 1'b1;
                    else if (on) exp_paused = 1'b0;
                end
            end
        end
        @(negedge clk); rx_valid = 1'b0; fifo_wr_ready = 1'b1; #1;
        check("R4 paused end", tx_paused, exp_paused);
        cfg_spec_en = 1'b0;

        // Transmit insertion: R6 R7 R8 for each transmit select
        cfg_wlen = 2'd3;
        for (int tm = 0; tm < 4; tm++) begin
            logic [7:0] s0, s1, g0, g1;
            int n;
            cfg_flow_mode = {2'(tm), 2'b00};
            fifo_level = 8'd9;
            txq_valid = 1'b0;
            do_reset();
            collect(6);
            check("R7 no resume without stop", got_n, 0);
            n  = (tm == 0) ? 0 : (tm == 3) ? 2 : 1;
            s0 = (tm == 2) ? OFF2 : OFF1; s1 = OFF2;
            g0 = (tm == 2) ? ON2 : ON1;   g1 = ON2;
            @(negedge clk); fifo_level = 8'd11;
            collect(6);
            check("R6 R8 stop count", got_n, n);
            if (n > 0) check("R6 R8 stop char 0", got[0], s0);
            if (n > 1) check("R8 stop char 1", got[1], s1);
            collect(6);
            check("R6 no repeat", got_n, 0);
            @(negedge clk); fifo_level = 8'd10;
            collect(6);
            check("R7 equal level idle", got_n, 0);
            @(negedge clk); fifo_level = 8'd9;
            collect(6);
            check("R7 R8 resume count", got_n, n);
            if (n > 0) check("R7 R8 resume char 0", got[0], g0);
            if (n > 1) check("R8 resume char 1", got[1], g1);
        end

        // R2: inserted character masked to 5 bits
        cfg_wlen = 2'd0; cfg_flow_mode = 4'b1000; fifo_level = 8'd9;
        do_reset();
        @(negedge clk); fifo_level = 8'd11;
        collect(4);
        check("R2 masked insert", got[0], OFF2 & 8'h1f);

        // R9 priority over queue data
        cfg_wlen = 2'd3; cfg_flow_mode = 4'b0101; fifo_level = 8'd9;
        do_reset();
        txq_valid = 1'b1;
        collect(1);
        check("R9 queue flows", got[0], 8'h55);
        @(negedge clk); fifo_level = 8'd11;
        collect(3);
        check("R9 insert first", got[0], OFF1);
        check("R9 queue after", got[1], 8'h55);

        // R4 pause by received stop, R9 insert while paused
        @(negedge clk); rx_valid = 1'b1; rx_data = OFF1;
        @(negedge clk); rx_valid = 1'b0; #1;
        check("R4 paused by stop", tx_paused, 1);
        check("R4 queue held", ser_valid, 0);
        check("R4 txq_ready low", txq_ready, 0);
        @(negedge clk); fifo_level = 8'd9;
        collect(4);
        check("R9 resume while paused count", got_n, 1);
        check("R9 resume while paused char", got[0], ON1);
        @(negedge clk); rx_valid = 1'b1; rx_data = ON1;
        @(negedge clk); rx_valid = 1'b0; #1;
        check("R4 resumed", tx_paused, 0);
        collect(1);
        check("R4 queue released", got[0], 8'h55);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule